// File: doc/BRIEF.md
# Macro-Op Group Packer

The packer sits between instruction decode and the scheduler. Each cycle it looks at a window of up to three decoded instructions in program order and builds one output group of three slots. Instructions come in three kinds. A single-op instruction yields one macro-op. A double-op instruction yields two. A microcoded instruction yields three or more, and a small stub sequencer expands those from a base payload. Every macro-op is a packed word that holds an arithmetic operation and an optional memory-address operation, so later stages can split the two apart.

Groups are filled oldest-first. If a double-op instruction arrives when only one slot is left, its first half takes that slot and its second half opens the next group. Simple and microcoded macro-ops are never placed in the same group. The packer does not wait to fill a group: any unused slots are marked empty and the group is sent anyway. The output group is registered. While the downstream side is stalled, the group already on the output is held and no instruction is consumed. The upstream window shifts by the reported take count on every clock edge.

Top module: `mgp_group_packer`

## Requirements
- R1: After reset all three output slot valid bits are 0, and with no valid input instruction `in_take` is 0.
- R2: Three single-op simple instructions in the window are emitted together in one group, in program order in slots 0, 1, 2.
- R3: A double-op plus a single-op instruction, in either order, fill one group: the double's two macro-ops are adjacent and in order (`in_mop0` then `in_mop1`).
- R4: When only slot 2 remains for a double-op instruction, its first macro-op goes in slot 2 and its second macro-op goes in slot 0 of the next group, so three consecutive doubles come out as two full groups.
- R5: A microcoded instruction (`in_ucode`=1) at the window head with length L emits its macro-ops three per group over consecutive groups. The last group holds L mod 3 ops, or three ops when L is a multiple of 3. Macro-op k is {base_alu+k, k[0], base_mem XOR k}, where base_alu and base_mem are the ALU and memory fields of the head's `in_mop0`. The instruction counts in `in_take` only in the cycle of its final chunk.
- R6: A group never mixes simple and microcoded macro-ops. Simple packing stops at a microcoded instruction, and a carried second half is emitted without any microcoded op beside it.
- R7: While `out_ready` is 0 and the output holds a valid slot, the output group stays unchanged and `in_take` is 0.
- R8: Slot 0 holds the oldest macro-op, and empty slots occur only at the tail, so the valid pattern is one of 000, 001, 011, 111 (bit 0 = slot 0).
- R9: `in_take` gives how many window instructions are consumed at the next clock edge (0 to 3), and it never exceeds the number of valid window entries.
- R10: A macro-op word is {alu[ALU_W], mem_en, mem[MEM_W]} from MSB to LSB. Simple-path words pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 3 | Window entry valid, bit 0 oldest |
| in_ucode | input | 3 | Entry is microcoded |
| in_dbl | input | 3 | Simple entry yields two macro-ops |
| in_mop0 | input | 3 x MOP_W | First macro-op, or microcode base for a microcoded entry |
| in_mop1 | input | 3 x MOP_W | Second macro-op of a double-op entry |
| in_head_len | input | LEN_W | Macro-op count of a microcoded head entry |
| out_ready | input | 1 | Downstream accepts the current group |
| out_slot_vld | output | 3 | Per-slot valid of the output group |
| out_slot_mop | output | 3 x MOP_W | Output slot payloads |
| in_take | output | 2 | Instructions consumed at the next edge |

## Verification
Most internal faults show up at the ports within one group. If the carried second half is lost or corrupted, the slot 0 of the group after a straddle is wrong. If the sequencer index is stale, the very next microcoded chunk comes out with wrong payloads, or it repeats or drops a chunk. If the take count is wrong, the upstream window shifts by the wrong amount. That appears one group later as duplicated or missing instructions, or as an empty group where data was expected.

// File: rtl/mgp_pkg.sv
// Shared constants and types for the macro-op group packer.
package mgp_pkg;
    localparam int GRP_SLOTS = 3;   // slots per output group
    localparam int WIN_DEPTH = 3;   // instructions visible per cycle

    // Which path produced the group being built
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_SIMPLE = 2'd1,
        SRC_UCODE  = 2'd2
    } grp_src_e;
endpackage

// File: rtl/mgp_simple_fill.sv
// Combinational packer for the simple path.
// Places a carried second half first, then walks the window oldest-first,
// stopping at the first invalid or microcoded entry or when the group is full.
// A double that finds a single free slot is split; its tail is returned as
// the next carry. Assumes the caller only uses the result for simple groups.
module mgp_simple_fill
    import mgp_pkg::*;
#(
    parameter int MOP_W = 17
) (
    input  logic                                carry_vld,
    input  logic [MOP_W-1:0]                    carry_mop,
    input  logic [WIN_DEPTH-1:0]                win_vld,
    input  logic [WIN_DEPTH-1:0]                win_uc,
    input  logic [WIN_DEPTH-1:0]                win_dbl,
    input  logic [WIN_DEPTH-1:0][MOP_W-1:0]     win_m0,
    input  logic [WIN_DEPTH-1:0][MOP_W-1:0]     win_m1,
    output logic [GRP_SLOTS-1:0]                slot_vld,
    output logic [GRP_SLOTS-1:0][MOP_W-1:0]     slot_mop,
    output logic [1:0]                          take,
    output logic                                nxt_carry_vld,
    output logic [MOP_W-1:0]                    nxt_carry_mop
);
    localparam logic [2:0] FULL = 3'(GRP_SLOTS);

    // Fill slots in program order under the pairing rules
    always_comb begin
        logic [2:0] used;
        logic       blocked;
        slot_vld      = '0;
        slot_mop      = '0;
        take          = 2'd0;
        nxt_carry_vld = 1'b0;
        nxt_carry_mop = '0;
        used          = 3'd0;
        blocked       = 1'b0;
        if (carry_vld) begin
            slot_vld[0] = 1'b1;
            slot_mop[0] = carry_mop;
            used        = 3'd1;
        end
        for (int i = 0; i < WIN_DEPTH; i++) begin
            if (blocked || !win_vld[i] || win_uc[i] || used >= FULL) begin
                blocked = 1'b1;
            end else if (!win_dbl[i]) begin
                slot_vld[used[1:0]] = 1'b1;
                slot_mop[used[1:0]] = win_m0[i];
                used = used + 3'd1;
                take = take + 2'd1;
            end else if (used + 3'd2 <= FULL) begin
                slot_vld[used[1:0]]         = 1'b1;
                slot_mop[used[1:0]]         = win_m0[i];
                slot_vld[used[1:0] + 2'd1]  = 1'b1;
                slot_mop[used[1:0] + 2'd1]  = win_m1[i];
                used = used + 3'd2;
                take = take + 2'd1;
            end else begin
                slot_vld[used[1:0]] = 1'b1;
                slot_mop[used[1:0]] = win_m0[i];
                nxt_carry_vld       = 1'b1;
                nxt_carry_mop       = win_m1[i];
                used = FULL;
                take = take + 2'd1;
            end
        end
    end
endmodule

// File: rtl/mgp_uc_seq.sv
// Stub microcode sequencer. Expands the head microcoded instruction into
// up to three macro-ops per group. It keeps a running index and derives
// op k from the base payload. Assumes the head entry is held stable by
// upstream until its final chunk is taken.
module mgp_uc_seq
    import mgp_pkg::*;
#(
    parameter int ALU_W = 8,
    parameter int MEM_W = 8,
    parameter int LEN_W = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        active,
    input  logic                                        advance,
    input  logic [ALU_W-1:0]                            base_alu,
    input  logic [MEM_W-1:0]                            base_mem,
    input  logic [LEN_W-1:0]                            len,
    output logic [GRP_SLOTS-1:0]                        slot_vld,
    output logic [GRP_SLOTS-1:0][ALU_W+MEM_W:0]         slot_mop,
    output logic                                        last
);
    localparam int PW = LEN_W + 1;

    logic [LEN_W-1:0] idx_q;
    logic [PW-1:0]    remain;

    // Ops still owed for the head instruction
    assign remain = {1'b0, len} - {1'b0, idx_q};
    assign last   = remain <= PW'(GRP_SLOTS);

    for (genvar k = 0; k < GRP_SLOTS; k++) begin : g_op
        logic [PW-1:0] pos;
        assign pos         = {1'b0, idx_q} + PW'(k);
        assign slot_vld[k] = active && (PW'(k) < remain);
        assign slot_mop[k] = {base_alu + ALU_W'(pos), pos[0], base_mem ^ MEM_W'(pos)};
    end

    // Step the index per emitted chunk, rewind after the final one
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (active && advance) idx_q <= last ? '0 : idx_q + LEN_W'(GRP_SLOTS);
    end

    a_r5_idx_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != '0) |-> (active && idx_q < len));
    a_r5_chunk_full: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |-> (&slot_vld));
endmodule

// File: rtl/mgp_group_reg.sv
// Output group register. Loads a new group when enabled, otherwise holds.
// Assumes the incoming valid pattern is already tail-packed.
module mgp_group_reg
    import mgp_pkg::*;
#(
    parameter int MOP_W = 17
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [GRP_SLOTS-1:0]            d_vld,
    input  logic [GRP_SLOTS-1:0][MOP_W-1:0] d_mop,
    output logic [GRP_SLOTS-1:0]            q_vld,
    output logic [GRP_SLOTS-1:0][MOP_W-1:0] q_mop
);
    // Capture the group presented for this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
            q_mop <= '0;
        end else if (load) begin
            q_vld <= d_vld;
            q_mop <= d_mop;
        end
    end

    a_r8_tail_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld == 3'b000) || (q_vld == 3'b001) || (q_vld == 3'b011) || (q_vld == 3'b111));
endmodule

// File: rtl/mgp_group_packer.sv
// Macro-op group packer top. Selects a simple group (with any carried half)
// or a microcoded chunk, never both, and registers it as a three-slot group.
// Assumes upstream shifts its window by in_take at every clock edge.
module mgp_group_packer
    import mgp_pkg::*;
#(
    parameter int ALU_W = 8,
    parameter int MEM_W = 8,
    parameter int LEN_W = 4,
    parameter int MOP_W = ALU_W + 1 + MEM_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WIN_DEPTH-1:0]            in_vld,
    input  logic [WIN_DEPTH-1:0]            in_ucode,
    input  logic [WIN_DEPTH-1:0]            in_dbl,
    input  logic [WIN_DEPTH-1:0][MOP_W-1:0] in_mop0,
    input  logic [WIN_DEPTH-1:0][MOP_W-1:0] in_mop1,
    input  logic [LEN_W-1:0]                in_head_len,
    input  logic                            out_ready,
    output logic [GRP_SLOTS-1:0]            out_slot_vld,
    output logic [GRP_SLOTS-1:0][MOP_W-1:0] out_slot_mop,
    output logic [1:0]                      in_take
);
    logic                            load;
    logic                            carry_vld;
    logic [MOP_W-1:0]                carry_mop;
    logic                            uc_active;
    grp_src_e                        src;
    logic [GRP_SLOTS-1:0]            fill_vld;
    logic [GRP_SLOTS-1:0][MOP_W-1:0] fill_mop;
    logic [1:0]                      fill_take;
    logic                            fill_cvld;
    logic [MOP_W-1:0]                fill_cmop;
    logic [GRP_SLOTS-1:0]            uc_vld;
    logic [GRP_SLOTS-1:0][MOP_W-1:0] uc_mop;
    logic                            uc_last;
    logic [GRP_SLOTS-1:0]            grp_vld;
    logic [GRP_SLOTS-1:0][MOP_W-1:0] grp_mop;

    // A new group may load when the output is empty or accepted
    assign load      = out_ready || !(|out_slot_vld);
    // Microcode runs only from the head and never beside a carried half
    assign uc_active = in_vld[0] && in_ucode[0] && !carry_vld;

    mgp_simple_fill #(.MOP_W(MOP_W)) u_fill (
        .carry_vld     (carry_vld),
        .carry_mop     (carry_mop),
        .win_vld       (in_vld),
        .win_uc        (in_ucode),
        .win_dbl       (in_dbl),
        .win_m0        (in_mop0),
        .win_m1        (in_mop1),
        .slot_vld      (fill_vld),
        .slot_mop      (fill_mop),
        .take          (fill_take),
        .nxt_carry_vld (fill_cvld),
        .nxt_carry_mop (fill_cmop)
    );

    mgp_uc_seq #(.ALU_W(ALU_W), .MEM_W(MEM_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (uc_active),
        .advance  (load),
        .base_alu (in_mop0[0][MOP_W-1 -: ALU_W]),
        .base_mem (in_mop0[0][MEM_W-1:0]),
        .len      (in_head_len),
        .slot_vld (uc_vld),
        .slot_mop (uc_mop),
        .last     (uc_last)
    );

    // Pick the source of this cycle's group
    always_comb begin
        if (uc_active)      src = SRC_UCODE;
        else if (|fill_vld) src = SRC_SIMPLE;
        else                src = SRC_IDLE;
    end

    // Route the chosen group and the consume count
    always_comb begin
        grp_vld = '0;
        grp_mop = '0;
        in_take = 2'd0;
        case (src)
            SRC_UCODE: begin
                grp_vld = uc_vld;
                grp_mop = uc_mop;
                in_take = load ? {1'b0, uc_last} : 2'd0;
            end
            SRC_SIMPLE: begin
                grp_vld = fill_vld;
                grp_mop = fill_mop;
                in_take = load ? fill_take : 2'd0;
            end
            default: ;
        endcase
    end

    // Hold the split-off second half of a double across groups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_vld <= 1'b0;
            carry_mop <= '0;
        end else if (load) begin
            carry_vld <= (src == SRC_SIMPLE) && fill_cvld;
            carry_mop <= fill_cmop;
        end
    end

    mgp_group_reg #(.MOP_W(MOP_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d_vld (grp_vld),
        .d_mop (grp_mop),
        .q_vld (out_slot_vld),
        .q_mop (out_slot_mop)
    );

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready && |out_slot_vld) |=> ($stable(out_slot_vld) && $stable(out_slot_mop)));
    a_r4_carry_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (load && carry_vld) |=> (out_slot_vld[0] && out_slot_mop[0] == $past(carry_mop)));
    a_r9_take_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(in_take) <= $countones(in_vld));
endmodule

// File: tb/test_mgp_group_packer.sv
// Directed bench: one task per scenario, each checks its own groups.
module test_mgp_group_packer;
    localparam int MW = 17;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [2:0]          in_vld, in_ucode, in_dbl;
    logic [2:0][MW-1:0]  in_mop0, in_mop1;
    logic [3:0]          in_head_len;
    logic                out_ready;
    logic [2:0]          out_slot_vld;
    logic [2:0][MW-1:0]  out_slot_mop;
    logic [1:0]          in_take;

    logic [MW-1:0] pm0 [64];
    logic [MW-1:0] pm1 [64];
    logic          pu  [64];
    logic          pd  [64];
    logic [3:0]    pl  [64];
    int head, cnt, n_cmp, n_bad;
    bit done;

    always #4 clk = ~clk;

    mgp_group_packer i_mgp_group_packer (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ucode(in_ucode), .in_dbl(in_dbl),
        .in_mop0(in_mop0), .in_mop1(in_mop1), .in_head_len(in_head_len),
        .out_ready(out_ready), .out_slot_vld(out_slot_vld), .out_slot_mop(out_slot_mop),
        .in_take(in_take)
    );

    // Upstream window model: present list[head..head+2]
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            int j;
            j = head + i;
            in_vld[i]   = (j < cnt);
            in_ucode[i] = (j < 64) ? pu[j]  : 1'b0;
            in_dbl[i]   = (j < 64) ? pd[j]  : 1'b0;
            in_mop0[i]  = (j < 64) ? pm0[j] : '0;
            in_mop1[i]  = (j < 64) ? pm1[j] : '0;
        end
        in_head_len = (head < 64) ? pl[head] : 4'd0;
    end

    always @(posedge clk) begin
        if (!rst_n) head <= 0;
        else        head <= head + int'(in_take);
    end

    function automatic logic [MW-1:0] mk(input logic [7:0] a, input logic e, input logic [7:0] m);
        return {a, e, m};
    endfunction

    function automatic logic [MW-1:0] ux(input logic [7:0] ba, input logic [7:0] bm, input int k);
        logic [7:0] kk;
        kk = 8'(k);
        return {ba + kk, kk[0], bm ^ kk};
    endfunction

    task automatic add_s(input logic [MW-1:0] a);
        pm0[cnt] = a; pm1[cnt] = '0; pu[cnt] = 0; pd[cnt] = 0; pl[cnt] = 0; cnt++;
    endtask
    task automatic add_d(input logic [MW-1:0] a, input logic [MW-1:0] b);
        pm0[cnt] = a; pm1[cnt] = b; pu[cnt] = 0; pd[cnt] = 1; pl[cnt] = 0; cnt++;
    endtask
    task automatic add_u(input logic [7:0] ba, input logic [7:0] bm, input logic [3:0] len);
        pm0[cnt] = mk(ba, 1'b0, bm); pm1[cnt] = '0; pu[cnt] = 1; pd[cnt] = 0; pl[cnt] = len; cnt++;
    endtask

    task automatic chk_grp(input string req, input logic [2:0] ev,
                           input logic [MW-1:0] e0, input logic [MW-1:0] e1, input logic [MW-1:0] e2);
        logic ok;
        ok = (out_slot_vld == ev);
        if (ev[0] && out_slot_mop[0] !== e0) ok = 0;
        if (ev[1] && out_slot_mop[1] !== e1) ok = 0;
        if (ev[2] && out_slot_mop[2] !== e2) ok = 0;
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got vld=%b %h %h %h, expected vld=%b %h %h %h", req,
                     out_slot_vld, out_slot_mop[0], out_slot_mop[1], out_slot_mop[2], ev, e0, e1, e2);
        end
    endtask

    task automatic chk_take(input string req, input logic [1:0] exp);
        n_cmp++;
        if (in_take !== exp) begin
            n_bad++;
            $display("FAIL %s: in_take=%0d expected %0d", req, in_take, exp);
        end
    endtask

    task automatic t_reset;
        chk_grp("R1 reset slots", 3'b000, '0, '0, '0);
        chk_take("R1 reset take", 2'd0);
    endtask

    task automatic t_singles;  // R2, R9, R10
        add_s(mk(8'h11, 1, 8'hA1)); add_s(mk(8'h12, 0, 8'hA2)); add_s(mk(8'h13, 1, 8'hA3));
        #1 chk_take("R9 three singles take", 2'd3);
        @(negedge clk);
        chk_grp("R2 R10 three singles", 3'b111, mk(8'h11, 1, 8'hA1), mk(8'h12, 0, 8'hA2), mk(8'h13, 1, 8'hA3));
        @(negedge clk);
        chk_grp("R8 idle group empty", 3'b000, '0, '0, '0);
    endtask

    task automatic t_dbl_single;  // R3
        add_d(mk(8'h21, 0, 8'h01), mk(8'h22, 1, 8'h02)); add_s(mk(8'h23, 0, 8'h03));
        @(negedge clk);
        chk_grp("R3 double then single", 3'b111, mk(8'h21, 0, 8'h01), mk(8'h22, 1, 8'h02), mk(8'h23, 0, 8'h03));
        @(negedge clk);
        add_s(mk(8'h24, 1, 8'h04)); add_d(mk(8'h25, 0, 8'h05), mk(8'h26, 1, 8'h06));
        @(negedge clk);
        chk_grp("R3 single then double", 3'b111, mk(8'h24, 1, 8'h04), mk(8'h25, 0, 8'h05), mk(8'h26, 1, 8'h06));
        @(negedge clk);
    endtask

    task automatic t_three_dbl;  // R4
        add_d(mk(8'h31, 0, 0), mk(8'h32, 0, 0)); add_d(mk(8'h33, 0, 0), mk(8'h34, 0, 0));
        add_d(mk(8'h35, 0, 0), mk(8'h36, 0, 0));
        #1 chk_take("R4 R9 straddle take", 2'd2);
        @(negedge clk);
        chk_grp("R4 doubles group 1", 3'b111, mk(8'h31, 0, 0), mk(8'h32, 0, 0), mk(8'h33, 0, 0));
        @(negedge clk);
        chk_grp("R4 doubles group 2", 3'b111, mk(8'h34, 0, 0), mk(8'h35, 0, 0), mk(8'h36, 0, 0));
        @(negedge clk);
        chk_grp("R4 drained", 3'b000, '0, '0, '0);
    endtask

    task automatic t_ucode_long;  // R5
        add_u(8'h40, 8'h10, 4'd7);
        #1 chk_take("R5 no take before last chunk", 2'd0);
        @(negedge clk);
        chk_grp("R5 chunk 1", 3'b111, ux(8'h40, 8'h10, 0), ux(8'h40, 8'h10, 1), ux(8'h40, 8'h10, 2));
        @(negedge clk);
        chk_grp("R5 chunk 2", 3'b111, ux(8'h40, 8'h10, 3), ux(8'h40, 8'h10, 4), ux(8'h40, 8'h10, 5));
        chk_take("R5 take with last chunk", 2'd1);
        @(negedge clk);
        chk_grp("R5 chunk 3 padded", 3'b001, ux(8'h40, 8'h10, 6), '0, '0);
        @(negedge clk);
        chk_grp("R5 consumed once", 3'b000, '0, '0, '0);
    endtask

    task automatic t_mix_stop;  // R6
        add_s(mk(8'h51, 0, 8'h51)); add_s(mk(8'h52, 0, 8'h52)); add_u(8'h60, 8'h33, 4'd3);
        @(negedge clk);
        chk_grp("R6 simple stops at ucode", 3'b011, mk(8'h51, 0, 8'h51), mk(8'h52, 0, 8'h52), '0);
        @(negedge clk);
        chk_grp("R6 R5 ucode len 3", 3'b111, ux(8'h60, 8'h33, 0), ux(8'h60, 8'h33, 1), ux(8'h60, 8'h33, 2));
        @(negedge clk);
        chk_grp("R6 drained", 3'b000, '0, '0, '0);
    endtask

    task automatic t_carry_ucode;  // R6, R4
        add_s(mk(8'h71, 0, 0)); add_s(mk(8'h72, 0, 0)); add_d(mk(8'h73, 1, 0), mk(8'h74, 1, 1));
        add_u(8'h80, 8'hF0, 4'd4);
        @(negedge clk);
        chk_grp("R4 split first half", 3'b111, mk(8'h71, 0, 0), mk(8'h72, 0, 0), mk(8'h73, 1, 0));
        @(negedge clk);
        chk_grp("R6 carry alone", 3'b001, mk(8'h74, 1, 1), '0, '0);
        @(negedge clk);
        chk_grp("R6 ucode after carry", 3'b111, ux(8'h80, 8'hF0, 0), ux(8'h80, 8'hF0, 1), ux(8'h80, 8'hF0, 2));
        @(negedge clk);
        chk_grp("R5 ucode tail", 3'b001, ux(8'h80, 8'hF0, 3), '0, '0);
        @(negedge clk);
    endtask

    task automatic t_stall;  // R7
        out_ready = 1'b0;
        add_d(mk(8'h91, 0, 0), mk(8'h92, 0, 0)); add_d(mk(8'h93, 0, 0), mk(8'h94, 0, 0));
        add_d(mk(8'h95, 0, 0), mk(8'h96, 0, 0));
        @(negedge clk);
        chk_grp("R7 first group loads", 3'b111, mk(8'h91, 0, 0), mk(8'h92, 0, 0), mk(8'h93, 0, 0));
        chk_take("R7 no take while stalled", 2'd0);
        @(negedge clk);
        @(negedge clk);
        chk_grp("R7 held", 3'b111, mk(8'h91, 0, 0), mk(8'h92, 0, 0), mk(8'h93, 0, 0));
        chk_take("R7 still no take", 2'd0);
        out_ready = 1'b1;
        #1 chk_take("R7 resume take", 2'd1);
        @(negedge clk);
        chk_grp("R7 R4 resumed group", 3'b111, mk(8'h94, 0, 0), mk(8'h95, 0, 0), mk(8'h96, 0, 0));
        @(negedge clk);
        chk_grp("R7 drained", 3'b000, '0, '0, '0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            pm0[i] = '0; pm1[i] = '0; pu[i] = 0; pd[i] = 0; pl[i] = '0;
        end
        head = 0; cnt = 0; n_cmp = 0; n_bad = 0; done = 0;
        rst_n = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_singles();
        t_dbl_single();
        t_three_dbl();
        t_ucode_long();
        t_mix_stop();
        t_carry_ucode();
        t_stall();
        finish_run();
    end
endmodule